// File: doc/BRIEF.md
# Interrupt Flag Status Register

This block gathers three kinds of one-cycle event pulses into sticky flags: update-ended, alarm and periodic. Each flag is set whenever its event occurs, whatever the matching enable says. A small enable register gates the flags into one summary bit. That summary bit drives an active-low interrupt request, modelled as an output-enable that pulls the shared line low while it is high.

Software observes the flags through a status byte that is read to clear. While the read strobe is held, the byte is frozen. When the strobe drops, every flag that appeared in the frozen image is cleared. Events that arrive while the strobe is held are parked and posted once it drops, so none are lost.

An active-low synchronous reset clears all flags and the four enables. A SET-rise indication from the neighbouring control logic clears only the update-ended enable. A second read-only byte reports battery health.

Top module: `irq_flag_status`

## Requirements
- R1: The status byte carries the summary flag in bit 7, the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. Bits 3 to 0 always read 0.
- R2: The summary flag is (periodic AND periodic enable) OR (alarm AND alarm enable) OR (update AND update enable). `irq_drive_low` is 1 exactly when the summary flag is 1. The enable bits are `ctl_q[0]` for update, `ctl_q[1]` for alarm, `ctl_q[2]` for periodic and `ctl_q[3]` for square-wave.
- R3: An event pulse sets its flag at the next clock edge when no read is active, whether or not its enable is set.
- R4: When a flag is already set and its enable is then written to 1, `irq_drive_low` asserts in the cycle after the write edge.
- R5: While `rd_stat` is held, `stat_byte` stays constant. When `rd_stat` falls, every flag present in that image is cleared at the next edge, and the summary flag falls with the flags.
- R6: An event that arrives while `rd_stat` is high does not change the flags during the read. It is set at the edge on which the read completes.
- R7: While `rst_n` is low, a clock edge clears all flags, any parked events and all four enable bits.
- R8: A one-cycle `set_rise` pulse clears the update enable, `ctl_q[0]`, and leaves the other enable bits unchanged. `set_rise` takes priority over a write in the same cycle.
- R9: `health_byte` reads 0x80 when `batt_good` is 1 and 0x00 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_upd | input | 1 | Update-ended event pulse |
| evt_alm | input | 1 | Alarm event pulse |
| evt_per | input | 1 | Periodic event pulse |
| rd_stat | input | 1 | Status read strobe; high for the whole read |
| set_rise | input | 1 | Pulse when the SET control bit goes to 1 |
| ctl_we | input | 1 | Write strobe for the enable bits |
| ctl_wdata | input | 4 | New enable bits {sqw, per, alm, upd} |
| batt_good | input | 1 | Battery health indication |
| stat_byte | output | 8 | Read-to-clear status byte |
| health_byte | output | 8 | Read-only battery health byte |
| ctl_q | output | 4 | Current enable bits {sqw, per, alm, upd} |
| irq_drive_low | output | 1 | When 1, the interrupt line is pulled low |

## Verification
The hardest situation to reach is an event that lands inside a read window while a different flag sits in the frozen image. After the read, the captured flag must be gone and the new one must be present. The bench first sets the alarm flag with its enable off, then raises `rd_stat`. It pulses the update-ended event while the strobe is held and checks that the status byte does not move. It then drops the strobe and expects only the update-ended bit to remain. Late enabling is reached in a similar way: the bench sets a flag with its enable off, then writes the enable and checks the interrupt one cycle later.

// File: rtl/irq_flag_pkg.sv
// Shared constants for the interrupt flag status block.
// Source index i maps to status bit FLAG_LSB+i and enable bit i.
package irq_flag_pkg;
    localparam int NUM_SRC  = 3;
    localparam int SRC_UPD  = 0;
    localparam int SRC_ALM  = 1;
    localparam int SRC_PER  = 2;
    localparam int CTL_W    = NUM_SRC + 1;   // plus square-wave enable
    localparam int STAT_W   = 8;
    localparam int FLAG_LSB = 4;
    localparam int SUM_BIT  = STAT_W - 1;
endpackage

// File: rtl/irq_flag_cell.sv
// One sticky event flag with a parking bit for events that arrive during
// a status read. Assumes rd_done is a one-cycle pulse after rd_busy falls.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic rd_busy,
    input  logic rd_done,
    input  logic clr_seen,
    output logic flag
);
    logic park_q;

    // Set, park or retire the flag according to the read phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag   <= 1'b0;
            park_q <= 1'b0;
        end else if (rd_busy) begin
            if (evt) park_q <= 1'b1;
        end else if (rd_done) begin
            flag   <= (flag & ~clr_seen) | park_q | evt;
            park_q <= 1'b0;
        end else if (evt) begin
            flag <= 1'b1;
        end
    end
endmodule

// File: rtl/irq_enable_reg.sv
// Interrupt and square-wave enable bits. Reset clears all of them; a
// SET-rise pulse clears only the update enable and wins over a write.
module irq_enable_reg
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              set_rise,
    output logic [CTL_W-1:0]  q
);
    // Load written enables, then apply the SET-rise clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            if (we)       q          <= wdata;
            if (set_rise) q[SRC_UPD] <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_status_snap.sv
// Status image register: follows the live byte while idle and freezes
// while a read is held, giving software a stable view.
module irq_status_snap
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [STAT_W-1:0] live,
    output logic [STAT_W-1:0] q
);
    // Track the live byte unless a read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)     q <= '0;
        else if (!hold) q <= live;
    end
endmodule

// File: rtl/irq_flag_status.sv
// Interrupt flag status register: sticky flags per event source, enable
// gating into a summary request and a read-to-clear status image.
// Assumes event pulses are one cycle wide and rd_stat is held for a read.
module irq_flag_status
    import irq_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_upd,
    input  logic              evt_alm,
    input  logic              evt_per,
    input  logic              rd_stat,
    input  logic              set_rise,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              batt_good,
    output logic [STAT_W-1:0] stat_byte,
    output logic [STAT_W-1:0] health_byte,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              irq_drive_low
);
    logic [NUM_SRC-1:0] evt_vec;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] seen;
    logic [STAT_W-1:0]  live_byte;
    logic               rd_q;
    logic               rd_done;
    logic               summary;

    assign evt_vec[SRC_UPD] = evt_upd;
    assign evt_vec[SRC_ALM] = evt_alm;
    assign evt_vec[SRC_PER] = evt_per;

    // Remember the read strobe to find the end of a read.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= 1'b0;
        else        rd_q <= rd_stat;
    end
    assign rd_done = rd_q & ~rd_stat;

    assign seen = stat_byte[FLAG_LSB +: NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        irq_flag_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (evt_vec[i]),
            .rd_busy  (rd_stat),
            .rd_done  (rd_done),
            .clr_seen (seen[i]),
            .flag     (flags[i])
        );
    end

    irq_enable_reg u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctl_we),
        .wdata    (ctl_wdata),
        .set_rise (set_rise),
        .q        (ctl_q)
    );

    // Summary request from flags gated by their enables.
    always_comb begin
        summary = |(flags & ctl_q[NUM_SRC-1:0]);
        live_byte = '0;
        live_byte[SUM_BIT] = summary;
        live_byte[FLAG_LSB +: NUM_SRC] = flags;
    end

    irq_status_snap u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (rd_stat),
        .live  (live_byte),
        .q     (stat_byte)
    );

    assign irq_drive_low = summary;
    assign health_byte   = {batt_good, {(STAT_W-1){1'b0}}};
endmodule

// File: rtl/irq_flag_status_chk.sv
// Property checker for irq_flag_status, attached with bind below.
module irq_flag_status_chk
    import irq_flag_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rd_stat,
    input logic               rd_done,
    input logic               set_rise,
    input logic               evt_upd,
    input logic               evt_alm,
    input logic [STAT_W-1:0]  stat_byte,
    input logic [CTL_W-1:0]   ctl_q,
    input logic [NUM_SRC-1:0] flags,
    input logic               irq_drive_low
);
    assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_drive_low) |-> (ctl_q[NUM_SRC-1:0] != '0));

    assert_flag_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stat && !rd_done && evt_alm) |=> flags[SRC_ALM]);

    assert_snapshot_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && $past(rd_stat)) |-> $stable(stat_byte));

    assert_event_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && evt_upd && !flags[SRC_UPD]) |=> !flags[SRC_UPD]);

    assert_set_clears_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set_rise |=> !ctl_q[SRC_UPD]);
endmodule

bind irq_flag_status irq_flag_status_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_stat       (rd_stat),
    .rd_done       (rd_done),
    .set_rise      (set_rise),
    .evt_upd       (evt_upd),
    .evt_alm       (evt_alm),
    .stat_byte     (stat_byte),
    .ctl_q         (ctl_q),
    .flags         (flags),
    .irq_drive_low (irq_drive_low)
);

// File: tb/irq_flag_status_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module irq_flag_status_bench;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_upd = 1'b0, evt_alm = 1'b0, evt_per = 1'b0;
    logic       rd_stat = 1'b0, set_rise = 1'b0, ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'h0;
    logic       batt_good = 1'b1;
    logic [7:0] stat_byte, health_byte;
    logic [3:0] ctl_q;
    logic       irq_drive_low;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    irq_flag_status u_irq_flag_status (
        .clk(clk), .rst_n(rst_n), .evt_upd(evt_upd), .evt_alm(evt_alm),
        .evt_per(evt_per), .rd_stat(rd_stat), .set_rise(set_rise),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .batt_good(batt_good),
        .stat_byte(stat_byte), .health_byte(health_byte), .ctl_q(ctl_q),
        .irq_drive_low(irq_drive_low)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [3:0] v);
        ctl_we = 1'b1; ctl_wdata = v; tick(); ctl_we = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1; tick();
        check("R7 status after reset", stat_byte, 8'h00);
        check("R7 enables after reset", {4'h0, ctl_q}, 8'h00);
        check("R7 irq after reset", {7'h0, irq_drive_low}, 8'h00);
    endtask

    task automatic t_flag_no_enable();
        evt_per = 1'b1; tick(); evt_per = 1'b0;
        check("R3 irq stays off without enable", {7'h0, irq_drive_low}, 8'h00);
        tick();
        check("R1 R3 periodic flag in bit 6", stat_byte, 8'h40);
    endtask

    task automatic t_enable_late();
        write_ctl(4'b0100);
        check("R4 irq on at once after enable", {7'h0, irq_drive_low}, 8'h01);
        tick();
        check("R2 summary bit with periodic", stat_byte, 8'hC0);
    endtask

    task automatic t_read_clear();
        rd_stat = 1'b1; tick();
        check("R5 snapshot during read", stat_byte, 8'hC0);
        tick();
        check("R5 snapshot held", stat_byte, 8'hC0);
        rd_stat = 1'b0; tick();
        check("R5 irq off after read", {7'h0, irq_drive_low}, 8'h00);
        tick();
        check("R5 status cleared after read", stat_byte, 8'h00);
    endtask

    task automatic t_event_during_read();
        evt_alm = 1'b1; tick(); evt_alm = 1'b0; tick();
        check("R3 alarm flag without enable", stat_byte, 8'h20);
        rd_stat = 1'b1; tick();
        evt_upd = 1'b1; tick(); evt_upd = 1'b0;
        check("R6 event not shown during read", stat_byte, 8'h20);
        rd_stat = 1'b0; tick(); tick();
        check("R6 parked event posted, alarm cleared", stat_byte, 8'h10);
    endtask

    task automatic t_set_rise();
        write_ctl(4'b1111);
        check("R2 update flag with enable drives irq", {7'h0, irq_drive_low}, 8'h01);
        set_rise = 1'b1; ctl_we = 1'b1; ctl_wdata = 4'b1111; tick();
        set_rise = 1'b0; ctl_we = 1'b0;
        check("R8 only update enable cleared", {4'h0, ctl_q}, 8'h0E);
        check("R8 irq released", {7'h0, irq_drive_low}, 8'h00);
        evt_alm = 1'b1; tick(); evt_alm = 1'b0;
        check("R2 alarm with enable drives irq", {7'h0, irq_drive_low}, 8'h01);
        tick();
        check("R1 R2 summary, alarm and update bits", stat_byte, 8'hB0);
    endtask

    task automatic t_reset_clears();
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        check("R7 enables cleared", {4'h0, ctl_q}, 8'h00);
        check("R7 irq cleared", {7'h0, irq_drive_low}, 8'h00);
        check("R7 flags cleared", stat_byte, 8'h00);
    endtask

    task automatic t_health();
        batt_good = 1'b1; tick();
        check("R9 health good", health_byte, 8'h80);
        batt_good = 1'b0; tick();
        check("R9 health bad", health_byte, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_flag_no_enable();
        t_enable_late();
        t_read_clear();
        t_event_during_read();
        t_set_rise();
        t_reset_clears();
        t_health();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule